// File: doc/BRIEF.md
# Endian-Configurable Byte-Lane Steering

This block sits between a 32-bit little-endian core data path and a 32-bit external memory bus. For each access it takes the address, a byte/word size flag, a read/write flag and an endian-mode input. From these it produces one strobe per byte lane toward memory, places write data on the bus lanes and aligns data read from the bus into the value the core loads into a register. The wiring of the lanes never changes. Strobe i always covers bus bits 8i+7:8i. Only the choice of lane for a given byte address follows the endian mode.

Word accesses may use any address, including unaligned ones. An unaligned word read returns the aligned memory word rotated right by whole bytes and does not fault. A byte read is zero-extended. A byte write repeats the low register byte on every lane, and the single active strobe marks the lane that memory must take.

The steering logic is combinational. By default a register stage follows it, so a request applied in one cycle gives its response after the next rising clock edge.

Top module: `bus_lane_steer`

## Requirements
- R1: With the output register enabled, `rspValid` equals `reqValid` delayed by one clock edge, and each response belongs to the request captured at that edge. While `rst_n` is low, all outputs are zero.
- R2: A word access (`reqIsByte`=0) asserts all four lane strobes (`laneStrb`=4'b1111), whatever the address offset and endian mode.
- R3: A byte access asserts exactly one strobe. With offset n = `reqAddr[1:0]`, the strobe is lane n when `bigEndian`=0 and lane 3−n when `bigEndian`=1. Strobe bit i covers data bits 8i+7:8i.
- R4: A word read returns `memRdData` rotated right by 8·n bits, the same in both endian modes. For 0x11223344, offsets 1, 2 and 3 give 0x44112233, 0x33441122 and 0x22334411.
- R5: A byte read returns the strobed lane of `memRdData` zero-extended to 32 bits. For 0x11223344, offsets 0..3 give 0x44, 0x33, 0x22, 0x11 in little-endian mode and 0x11, 0x22, 0x33, 0x44 in big-endian mode.
- R6: A word write drives `wrData` onto `memWrData` unrotated, for every offset and both endian modes.
- R7: A byte write drives `wrData[7:0]` on all four lanes of `memWrData`.
- R8: A cycle without a request gives a response with `rspValid`=0 and with `laneStrb`, `memWrData` and `rdResult` all zero.
- R9: A write response has `rdResult`=0. A read response has `memWrData`=0.
- R10: Address bits above bit 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| reqValid | input | 1 | An access is presented this cycle |
| reqAddr | input | ADDR_W (32) | Byte address; only the low two bits steer |
| reqIsByte | input | 1 | 1 = byte access, 0 = word access |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| bigEndian | input | 1 | 1 = big-endian external memory |
| wrData | input | 32 | Register contents to be written |
| memRdData | input | 32 | Word returned by memory on the bus lanes |
| laneStrb | output | 4 | Per-lane byte strobes toward memory |
| memWrData | output | 32 | Steered write data on the bus lanes |
| rdResult | output | 32 | Aligned read value for the register file |
| rspValid | output | 1 | Outputs carry the previous cycle's request |

## Verification
The only state in the block is the output register. Because of this, every internal fault shows up at the ports in the response cycle of the request that triggers it. A wrong lane decode puts the strobe, and the byte read from it, on the mirrored lane. A wrong rotation select gives a byte-permuted word at that same edge. A stale or unreset output register shows up as non-zero strobes or data in an idle cycle right after the request. For this reason the bench runs every combination of size, offset, direction and endian mode, with idle cycles between the requests.

// File: rtl/lane_steer_pkg.sv
`timescale 1ns/1ps
package lane_steer_pkg;
  localparam int unsigned LANE_CNT = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned DATA_W   = LANE_CNT * BYTE_W;
  localparam int unsigned IDX_W    = $clog2(LANE_CNT);

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic                active;
    logic                isByte;
    logic                isWrite;
    logic [IDX_W-1:0]    rotAmt;
    logic [LANE_CNT-1:0] laneStrb;
  } steer_ctl_t;
endpackage

// File: rtl/lane_steer_ctrl.sv
`timescale 1ns/1ps
module lane_steer_ctrl
  import lane_steer_pkg::*;
(
  input  logic             reqValid,
  input  logic             reqIsByte,
  input  logic             reqIsWrite,
  input  logic             bigEndian,
  input  logic [IDX_W-1:0] byteOff,
  output steer_ctl_t       ctl
);
  logic [IDX_W-1:0]    laneIdx;
  logic [LANE_CNT-1:0] laneDecoded;

  // Big-endian memory mirrors the byte offset onto the lanes.
  assign laneIdx = bigEndian ? (IDX_W'(LANE_CNT - 1) - byteOff) : byteOff;

  for (genvar i = 0; i < LANE_CNT; i++) begin : g_dec
    assign laneDecoded[i] = (laneIdx == IDX_W'(i));
  end

  always_comb begin
    ctl.active  = reqValid;
    ctl.isByte  = reqIsByte;
    ctl.isWrite = reqIsWrite;
    ctl.rotAmt  = byteOff;
    if (!reqValid)      ctl.laneStrb = '0;
    else if (reqIsByte) ctl.laneStrb = laneDecoded;
    else                ctl.laneStrb = '1;
  end
endmodule

// File: rtl/lane_steer_dp.sv
`timescale 1ns/1ps
module lane_steer_dp
  import lane_steer_pkg::*;
(
  input  steer_ctl_t        ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] wrLanes,
  output logic [DATA_W-1:0] rdAligned
);
  logic [DATA_W-1:0] rotCand [LANE_CNT];
  logic [BYTE_W-1:0] rdLane  [LANE_CNT];
  logic [DATA_W-1:0] byteRep;
  logic [BYTE_W-1:0] bytePick;

  // One candidate per whole-byte rotate-right amount.
  for (genvar r = 0; r < LANE_CNT; r++) begin : g_rot
    if (r == 0) begin : g_none
      assign rotCand[r] = memRdData;
    end else begin : g_some
      assign rotCand[r] = {memRdData[r*BYTE_W-1:0], memRdData[DATA_W-1:r*BYTE_W]};
    end
  end

  for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
    assign rdLane[i]                 = memRdData[i*BYTE_W +: BYTE_W];
    assign byteRep[i*BYTE_W +: BYTE_W] = wrData[BYTE_W-1:0];
  end

  // The byte strobe doubles as the read-lane select.
  always_comb begin
    bytePick = '0;
    for (int i = 0; i < LANE_CNT; i++) begin
      bytePick |= rdLane[i] & {BYTE_W{ctl.laneStrb[i]}};
    end
  end

  always_comb begin
    if (!ctl.active || !ctl.isWrite) wrLanes = '0;
    else if (ctl.isByte)             wrLanes = byteRep;
    else                             wrLanes = wrData;
  end

  always_comb begin
    if (!ctl.active || ctl.isWrite) rdAligned = '0;
    else if (ctl.isByte)            rdAligned = {{(DATA_W-BYTE_W){1'b0}}, bytePick};
    else                            rdAligned = rotCand[ctl.rotAmt];
  end
endmodule

// File: rtl/bus_lane_steer.sv
`timescale 1ns/1ps
module bus_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqIsByte,
  input  logic                reqIsWrite,
  input  logic                bigEndian,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [LANE_CNT-1:0] laneStrb,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W-1:0]   rdResult,
  output logic                rspValid
);
  steer_ctl_t        ctl;
  logic [DATA_W-1:0] nextWr;
  logic [DATA_W-1:0] nextRd;
  logic              unusedAddrBits;

  assign unusedAddrBits = ^reqAddr[ADDR_W-1:IDX_W];

  lane_steer_ctrl ctrl_i (
    .reqValid  (reqValid),
    .reqIsByte (reqIsByte),
    .reqIsWrite(reqIsWrite),
    .bigEndian (bigEndian),
    .byteOff   (reqAddr[IDX_W-1:0]),
    .ctl       (ctl)
  );

  lane_steer_dp dp_i (
    .ctl      (ctl),
    .wrData   (wrData),
    .memRdData(memRdData),
    .wrLanes  (nextWr),
    .rdAligned(nextRd)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        laneStrb  <= '0;
        memWrData <= '0;
        rdResult  <= '0;
        rspValid  <= 1'b0;
      end else begin
        laneStrb  <= ctl.laneStrb;
        memWrData <= nextWr;
        rdResult  <= nextRd;
        rspValid  <= ctl.active;
      end
    end
  end else begin : g_comb
    assign laneStrb  = ctl.laneStrb;
    assign memWrData = nextWr;
    assign rdResult  = nextRd;
    assign rspValid  = ctl.active;
  end
endmodule

// File: rtl/bus_lane_steer_chk.sv
`timescale 1ns/1ps
module bus_lane_steer_chk
  import lane_steer_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic [IDX_W-1:0]    reqOff,
  input logic                reqIsByte,
  input logic                reqIsWrite,
  input logic                bigEndian,
  input logic [DATA_W-1:0]   wrData,
  input logic [LANE_CNT-1:0] laneStrb,
  input logic [DATA_W-1:0]   memWrData,
  input logic [DATA_W-1:0]   rdResult,
  input logic                rspValid
);
  if (REG_OUT) begin : g_chk
    logic              prevLive, prevValid, prevByte, prevWrite, prevBig;
    logic [IDX_W-1:0]  prevOff;
    logic [DATA_W-1:0] prevWr;
    logic [IDX_W-1:0]  expLane;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevLive <= 1'b0; prevValid <= 1'b0; prevByte <= 1'b0;
        prevWrite <= 1'b0; prevBig <= 1'b0; prevOff <= '0; prevWr <= '0;
      end else begin
        prevLive <= 1'b1; prevValid <= reqValid; prevByte <= reqIsByte;
        prevWrite <= reqIsWrite; prevBig <= bigEndian; prevOff <= reqOff;
        prevWr <= wrData;
      end
    end

    assign expLane = prevBig ? (IDX_W'(LANE_CNT - 1) - prevOff) : prevOff;

    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      prevLive |-> rspValid == prevValid);
    p_word_all_strb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (prevLive && rspValid && !prevByte) |-> laneStrb == '1);
    p_byte_one_strb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (prevLive && rspValid && prevByte) |-> ($countones(laneStrb) == 1 && laneStrb[expLane]));
    p_byte_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prevLive && rspValid && prevByte && !prevWrite) |-> rdResult[DATA_W-1:BYTE_W] == '0);
    p_word_wr_straight_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (prevLive && rspValid && !prevByte && prevWrite) |-> memWrData == prevWr);
    p_byte_wr_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prevLive && rspValid && prevByte && prevWrite) |-> memWrData == {LANE_CNT{prevWr[BYTE_W-1:0]}});
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rspValid |-> (laneStrb == '0 && memWrData == '0 && rdResult == '0));
    p_wr_no_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prevLive && rspValid && prevWrite) |-> rdResult == '0);
    p_rd_no_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prevLive && rspValid && !prevWrite) |-> memWrData == '0);
  end
endmodule

bind bus_lane_steer bus_lane_steer_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqOff    (reqAddr[IDX_W-1:0]),
  .reqIsByte (reqIsByte),
  .reqIsWrite(reqIsWrite),
  .bigEndian (bigEndian),
  .wrData    (wrData),
  .laneStrb  (laneStrb),
  .memWrData (memWrData),
  .rdResult  (rdResult),
  .rspValid  (rspValid)
);

// File: tb/bus_lane_steer_tb_top.sv
`timescale 1ns/1ps
module bus_lane_steer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqIsByte = 1'b0;
  logic        reqIsWrite = 1'b0;
  logic        bigEndian = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] memRdData = '0;
  logic [3:0]  laneStrb;
  logic [31:0] memWrData;
  logic [31:0] rdResult;
  logic        rspValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        valid;
    logic [3:0]  strb;
    logic [31:0] wr;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  bus_lane_steer dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqIsByte(reqIsByte), .reqIsWrite(reqIsWrite), .bigEndian(bigEndian),
    .wrData(wrData), .memRdData(memRdData), .laneStrb(laneStrb),
    .memWrData(memWrData), .rdResult(rdResult), .rspValid(rspValid)
  );

  // Drive one cycle and queue the expected response.
  task automatic send(input logic v, input logic isB, input logic isW, input logic be,
                      input logic [31:0] addr, input logic [31:0] wd, input logic [31:0] md,
                      input logic [3:0] eStrb, input logic [31:0] eWr, input logic [31:0] eRd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = v; reqIsByte = isB; reqIsWrite = isW; bigEndian = be;
    reqAddr = addr; wrData = wd; memRdData = md;
    e.valid = v; e.strb = eStrb; e.wr = eWr; e.rd = eRd; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Reference model taken from the requirements.
  task automatic sendModel(input logic isB, input logic isW, input logic be,
                           input logic [31:0] addr, input logic [31:0] wd,
                           input logic [31:0] md, input string tag);
    int off, lane;
    logic [63:0] dbl;
    logic [3:0]  s;
    logic [31:0] w, r;
    off  = int'(addr[1:0]);
    lane = be ? 3 - off : off;
    dbl  = {md, md} >> (8 * off);
    s = isB ? (4'b0001 << lane) : 4'b1111;
    w = !isW ? 32'h0 : (isB ? {4{wd[7:0]}} : wd);
    r = isW ? 32'h0 : (isB ? {24'h0, md[8*lane +: 8]} : dbl[31:0]);
    send(1'b1, isB, isW, be, addr, wd, md, s, w, r, tag);
  endtask

  task automatic idle();
    send(1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hCAFE_F00D,
         4'h0, 32'h0, 32'h0, "R8 idle");
  endtask

  // Monitor: compares one response per clock.
  always @(posedge clk) begin
    #2;
    if (rst_n && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      compared++;
      if (rspValid !== e.valid || laneStrb !== e.strb || memWrData !== e.wr || rdResult !== e.rd) begin
        mismatched++;
        $display("FAIL %s: actual v=%0b strb=%h wr=%h rd=%h expected v=%0b strb=%h wr=%h rd=%h",
                 e.tag, rspValid, laneStrb, memWrData, rdResult,
                 e.valid, e.strb, e.wr, e.rd);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    reqValid = 1'b1; reqIsWrite = 1'b1; wrData = 32'hFFFF_FFFF;
    repeat (2) @(posedge clk);
    #2;
    compared++;
    if (laneStrb !== 4'h0 || memWrData !== 32'h0 || rdResult !== 32'h0 || rspValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset: actual strb=%h wr=%h rd=%h v=%0b expected all zero",
               laneStrb, memWrData, rdResult, rspValid);
    end
    @(negedge clk);
    reqValid = 1'b0;
    rst_n = 1'b1;

    // Literal values for R4 and R5 (memory word 0x11223344).
    send(1, 0, 0, 0, 32'h0000_0001, 32'h0, 32'h1122_3344, 4'hF, 32'h0, 32'h4411_2233, "R4 off1 le");
    send(1, 0, 0, 1, 32'h0000_0002, 32'h0, 32'h1122_3344, 4'hF, 32'h0, 32'h3344_1122, "R4 off2 be");
    send(1, 0, 0, 1, 32'h0000_0003, 32'h0, 32'h1122_3344, 4'hF, 32'h0, 32'h2233_4411, "R4 off3 be");
    send(1, 1, 0, 0, 32'h0000_0000, 32'h0, 32'h1122_3344, 4'h1, 32'h0, 32'h0000_0044, "R3 R5 le off0");
    send(1, 1, 0, 1, 32'h0000_0000, 32'h0, 32'h1122_3344, 4'h8, 32'h0, 32'h0000_0011, "R3 R5 be off0");
    send(1, 1, 0, 1, 32'h0000_0001, 32'h0, 32'h1122_3344, 4'h4, 32'h0, 32'h0000_0022, "R3 R5 be off1");
    send(1, 1, 1, 1, 32'h0000_0000, 32'h1122_3344, 32'h0, 4'h8, 32'h4444_4444, 32'h0, "R7 R9 be off0");
    idle();

    // Every combination against the model, with gaps.
    for (int pat = 0; pat < 2; pat++) begin
      for (int be = 0; be < 2; be++) begin
        for (int sz = 0; sz < 2; sz++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int off = 0; off < 4; off++) begin
              logic [31:0] md, wd, addr;
              string tag;
              md = pat ? 32'hA5C3_0F96 : 32'h1122_3344;
              wd = pat ? 32'h5A3C_F069 : 32'h8877_6655;
              addr = {pat ? 30'h2AAA_AAAA : 30'h1555_5555, 2'(off)};
              tag = (sz == 0) ? (wr ? "R2 R6 R9 word wr" : "R2 R4 R9 word rd")
                              : (wr ? "R3 R7 R9 byte wr" : "R3 R5 R9 byte rd");
              sendModel(1'(sz), 1'(wr), 1'(be), addr, wd, md, tag);
              if (off == 3) idle();
            end
          end
        end
      end
    end

    // R10: same low bits, different upper bits, same answer.
    send(1, 1, 0, 1, 32'hFFFF_FFFE, 32'h0, 32'h1122_3344, 4'h2, 32'h0, 32'h0000_0033, "R10 upper ones");
    send(1, 1, 0, 1, 32'h0000_0002, 32'h0, 32'h1122_3344, 4'h2, 32'h0, 32'h0000_0033, "R10 upper zeros");
    send(1, 0, 1, 0, 32'h8000_0003, 32'hCAFE_BABE, 32'h0, 4'hF, 32'hCAFE_BABE, 32'h0, "R10 R6 word wr");
    idle();
    idle();

    while (expQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule